// File: doc/BRIEF.md
# Stopped-Clock Dual-Mono DAC Formatter

This block takes a two-channel serial audio stream (bit clock, channel select, serial data) and drives two single-channel 24-bit serial converters, one per channel. The converters share one data line. Each has its own bit clock and its own latch strobe. A converter's bit clock toggles only while its own channel's word is shifted out, and rests high at all other times. A converter therefore ignores the shared data line while the other channel is being sent.

All inputs are brought into a faster system clock domain through two-flop synchronizers. Edges of the input bit clock are found there, and every output is a flop. Each 16-bit input word is sent in the next slot of the same channel. It goes out as 16 data bits, MSB first, followed by 8 zero bits, so it fills the converter's upper 16 bits. After the last bit the data line stays still, and the latch strobe then pulses for one bit period. A slot that is cut short, either while the word is captured or while it is sent, produces no latch pulse.

Top module: `dual_mono_dac_fmt`

## Requirements
- R1: After reset, both converter bit clocks are high, both latch strobes are low and the shared data output is low.
- R2: A slot begins at the first input bit clock rise where channel select differs from its value at the previous rise. Channel select 0 is the left channel and 1 is the right channel. The bit at that rise is skipped. The next 16 rises capture the word MSB first, and bits at later rises are ignored.
- R3: A word captured in a slot is emitted in the next slot of the same channel as 24 bits, MSB first. The bits are the 16 captured bits followed by 8 zero bits.
- R4: While its word is emitted, a channel's converter bit clock goes low after input bit clock falls 0 to 23 of the slot. It returns high at each input rise, which gives exactly 24 rising edges. Outside that window the clock stays high.
- R5: A converter's bit clock stays high for the whole of a slot that belongs to the other channel.
- R6: The emitting channel's latch strobe goes high at the 26th input rise of the slot (slot rise index 25). It stays high for exactly one bit period, and only one latch strobe is ever high at a time.
- R7: A slot with fewer than 17 input rises discards its word. The next slot of that channel shows no bit clock activity and no latch pulse.
- R8: A slot with fewer than 26 input rises aborts the emission in progress, and no latch pulse follows.
- R9: The shared data line changes only while bit clocks are low or resting, never on a converter bit clock rising edge. It stays unchanged while a latch strobe is high, and carries the last zero pad bit then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the input bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Incoming serial bit clock |
| ws_i | input | 1 | Incoming channel select (0 left, 1 right) |
| sd_i | input | 1 | Incoming serial data |
| dac_sd_o | output | 1 | Shared serial data to both converters |
| dac_l_bclk_o | output | 1 | Gated bit clock of the left converter |
| dac_l_latch_o | output | 1 | Latch strobe of the left converter |
| dac_r_bclk_o | output | 1 | Gated bit clock of the right converter |
| dac_r_latch_o | output | 1 | Latch strobe of the right converter |

## Verification
The formatter is driven with full 32-bit slots carrying corner words (all ones, all zeros, a single MSB plus LSB) and a pseudo-random word sequence. Together they show MSB-first order, correct alignment against the zero pad, and whether the channels are kept apart. Skip bits and trailing bits are driven high, so capturing any bit outside the 16-bit window shows up as a wrong word. Short slots of 12 and 16 rises separate discarding from keeping. A 20-rise slot separates an aborted emission from a valid capture, and slots of exactly 17 and 26 rises test the two length thresholds. Between slots, the level of each converter clock shows whether the gating follows the right channel and the right bit window.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;

  // Edge events of the synchronized input bit clock plus sampled lines
  typedef struct packed {
    logic rise;
    logic fall;
    logic start;
    logic ws;
    logic sd;
  } bus_evt_t;
endpackage

// File: rtl/dmf_sync.sv
module dmf_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/dmf_frame.sv
module dmf_frame
  import dmf_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             ws_i,
  input  logic             sd_i,
  output bus_evt_t         evt_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output chan_e            ch_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             sck_q, ws_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    evt_o.rise  = sck_i & ~sck_q;
    evt_o.fall  = ~sck_i & sck_q;
    evt_o.start = evt_o.rise & (ws_i != ws_q);
    evt_o.ws    = ws_i;
    evt_o.sd    = sd_i;
    if (evt_o.start)           cnt_nxt_o = '0;
    else if (cnt_q == CNT_MAX) cnt_nxt_o = cnt_q;
    else                       cnt_nxt_o = cnt_q + 1'b1;
  end

  // Counter saturates so long slots never retrigger late events
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      ws_q  <= 1'b0;
      cnt_q <= CNT_MAX;
    end else begin
      sck_q <= sck_i;
      if (evt_o.rise) begin
        ws_q  <= ws_i;
        cnt_q <= cnt_nxt_o;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign ch_o  = chan_e'(ws_q);
endmodule

// File: rtl/dmf_capture.sv
module dmf_capture
  import dmf_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int CNT_W = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  bus_evt_t               evt_i,
  input  logic [CNT_W-1:0]       cnt_i,
  input  logic [CNT_W-1:0]       cnt_nxt_i,
  input  chan_e                  ch_i,
  output logic [1:0][IN_W-1:0]   hold_o,
  output logic [1:0]             valid_o
);
  localparam logic [CNT_W-1:0] IN_LAST  = CNT_W'(IN_W);
  localparam logic [CNT_W-1:0] IN_FIRST = CNT_W'(1);

  logic            armed_q;
  logic [IN_W-1:0] sh_q;
  logic            in_window;

  assign in_window = (cnt_nxt_i >= IN_FIRST) && (cnt_nxt_i <= IN_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      sh_q    <= '0;
      hold_o  <= '0;
      valid_o <= '0;
    end else if (evt_i.start) begin
      // Closing slot: keep the word only if all bits arrived
      hold_o[ch_i]  <= sh_q;
      valid_o[ch_i] <= armed_q && (cnt_i >= IN_LAST);
      armed_q       <= 1'b1;
    end else if (evt_i.rise && in_window) begin
      sh_q <= {sh_q[IN_W-2:0], evt_i.sd};
    end
  end
endmodule

// File: rtl/dmf_emit.sv
module dmf_emit
  import dmf_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int DAC_W = 24,
  parameter int CNT_W = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  bus_evt_t             evt_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic [CNT_W-1:0]     cnt_nxt_i,
  input  chan_e                ch_i,
  input  logic [1:0][IN_W-1:0] hold_i,
  input  logic [1:0]           valid_i,
  output logic                 dout_o,
  output logic [1:0]           bclk_o,
  output logic [1:0]           latch_o
);
  localparam int               PAD     = DAC_W - IN_W;
  localparam logic [CNT_W-1:0] BIT_END = CNT_W'(DAC_W);
  localparam logic [CNT_W-1:0] LAT_ON  = CNT_W'(DAC_W + 1);
  localparam logic [CNT_W-1:0] LAT_OFF = CNT_W'(DAC_W + 2);

  logic             act_q;
  logic [DAC_W-1:0] sh_q;
  logic             shift_en;

  assign shift_en = evt_i.fall && act_q && (cnt_i < BIT_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      sh_q   <= '0;
      dout_o <= 1'b0;
    end else if (evt_i.start) begin
      act_q <= valid_i[evt_i.ws];
      sh_q  <= {hold_i[evt_i.ws], {PAD{1'b0}}};
    end else if (shift_en) begin
      dout_o <= sh_q[DAC_W-1];
      sh_q   <= {sh_q[DAC_W-2:0], 1'b0};
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_chan
    logic bclk_q, latch_q;
    logic own;
    assign own = act_q && (ch_i == chan_e'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bclk_q  <= 1'b1;
        latch_q <= 1'b0;
      end else begin
        if (evt_i.rise)                      bclk_q <= 1'b1;
        else if (shift_en && own)            bclk_q <= 1'b0;
        if (evt_i.start)                     latch_q <= 1'b0;
        else if (evt_i.rise && cnt_nxt_i == LAT_ON && own) latch_q <= 1'b1;
        else if (evt_i.rise && cnt_nxt_i == LAT_OFF)       latch_q <= 1'b0;
      end
    end

    assign bclk_o[c]  = bclk_q;
    assign latch_o[c] = latch_q;
  end
endmodule

// File: rtl/dual_mono_dac_fmt.sv
module dual_mono_dac_fmt
  import dmf_pkg::*;
#(
  parameter int IN_W        = 16,
  parameter int DAC_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic dac_sd_o,
  output logic dac_l_bclk_o,
  output logic dac_l_latch_o,
  output logic dac_r_bclk_o,
  output logic dac_r_latch_o
);
  localparam int CNT_W = $clog2(DAC_W + 3);

  logic [2:0]           sync_q;
  bus_evt_t             evt;
  logic [CNT_W-1:0]     cnt, cnt_nxt;
  chan_e                ch;
  logic [1:0][IN_W-1:0] hold;
  logic [1:0]           valid;
  logic [1:0]           bclk, latch;

  dmf_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i({sck_i, ws_i, sd_i}), .q_o(sync_q)
  );

  dmf_frame #(.CNT_W(CNT_W)) u_frame (
    .clk_i, .rst_ni,
    .sck_i(sync_q[2]), .ws_i(sync_q[1]), .sd_i(sync_q[0]),
    .evt_o(evt), .cnt_o(cnt), .cnt_nxt_o(cnt_nxt), .ch_o(ch)
  );

  dmf_capture #(.IN_W(IN_W), .CNT_W(CNT_W)) u_capture (
    .clk_i, .rst_ni, .evt_i(evt), .cnt_i(cnt), .cnt_nxt_i(cnt_nxt),
    .ch_i(ch), .hold_o(hold), .valid_o(valid)
  );

  dmf_emit #(.IN_W(IN_W), .DAC_W(DAC_W), .CNT_W(CNT_W)) u_emit (
    .clk_i, .rst_ni, .evt_i(evt), .cnt_i(cnt), .cnt_nxt_i(cnt_nxt),
    .ch_i(ch), .hold_i(hold), .valid_i(valid),
    .dout_o(dac_sd_o), .bclk_o(bclk), .latch_o(latch)
  );

  assign dac_l_bclk_o  = bclk[CH_LEFT];
  assign dac_r_bclk_o  = bclk[CH_RIGHT];
  assign dac_l_latch_o = latch[CH_LEFT];
  assign dac_r_latch_o = latch[CH_RIGHT];
endmodule

// File: rtl/dual_mono_dac_fmt_chk.sv
module dual_mono_dac_fmt_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic dac_sd_o,
  input logic dac_l_bclk_o,
  input logic dac_l_latch_o,
  input logic dac_r_bclk_o,
  input logic dac_r_latch_o
);
  // R5: at most one converter clock is ever running
  a_r5_one_clock_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_l_bclk_o || dac_r_bclk_o);

  // R6: never both strobes together
  a_r6_single_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dac_l_latch_o, dac_r_latch_o}));

  // R6: clocks rest while a strobe is active
  a_r6_latch_clocks_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_l_latch_o || dac_r_latch_o) |-> (dac_l_bclk_o && dac_r_bclk_o));

  // R6: strobe lasts longer than one system cycle
  a_r6_latch_width_l: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dac_l_latch_o) |=> dac_l_latch_o);
  a_r6_latch_width_r: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dac_r_latch_o) |=> dac_r_latch_o);

  // R9: data still during the strobe
  a_r9_data_held_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_l_latch_o || dac_r_latch_o) |-> $stable(dac_sd_o));

  // R9: data never moves on a sampling edge
  a_r9_data_stable_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dac_l_bclk_o) || $rose(dac_r_bclk_o)) |-> $stable(dac_sd_o));
endmodule

bind dual_mono_dac_fmt dual_mono_dac_fmt_chk u_chk (
  .clk_i, .rst_ni, .dac_sd_o, .dac_l_bclk_o, .dac_l_latch_o,
  .dac_r_bclk_o, .dac_r_latch_o
);

// File: tb/tb_dual_mono_dac_fmt.sv
module tb_dual_mono_dac_fmt;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b1, ws = 1'b0, sd = 1'b0;
  logic dsd, lb, ll, rb, rl;
  int   n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  dual_mono_dac_fmt dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .ws_i(ws), .sd_i(sd),
    .dac_sd_o(dsd), .dac_l_bclk_o(lb), .dac_l_latch_o(ll),
    .dac_r_bclk_o(rb), .dac_r_latch_o(rl)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Scoreboard queues of expected 24-bit emissions per channel
  logic [23:0] exp_l[$];
  logic [23:0] exp_r[$];
  bit          sv[2];
  logic [15:0] sw[2];

  task automatic send_slot(input bit ch, input int len, input logic [15:0] w);
    bit act = sv[ch];
    if (len >= 26 && act) begin
      if (ch) exp_r.push_back({sw[ch], 8'h00});
      else    exp_l.push_back({sw[ch], 8'h00});
    end
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      sck = 1'b0;
      ws  = ch;
      sd  = (k >= 1 && k <= 16) ? w[16-k] : 1'b1;
      repeat (7) @(negedge clk);
      if (k >= 1) begin
        logic own_b, oth_b;
        own_b = ch ? rb : lb;
        oth_b = ch ? lb : rb;
        check(oth_b == 1'b1, "R5", "other clock resting", {31'd0, oth_b}, 32'd1);
        if (act && k <= 24)
          check(own_b == 1'b0, "R4", "own clock low phase", {31'd0, own_b}, 32'd0);
        else
          check(own_b == 1'b1, act ? "R4" : "R7", "own clock resting",
                {31'd0, own_b}, 32'd1);
      end
      @(negedge clk);
      sck = 1'b1;
      repeat (7) @(negedge clk);
    end
    sv[ch] = (len >= 17);
    sw[ch] = w;
  endtask

  // Monitor: collects bits on converter clock rises, pops on strobe rise
  logic [23:0] col[2];
  logic        pb[2], pl[2];
  int          lat_w[2];
  initial begin
    col[0] = '0; col[1] = '0; pb[0] = 1'b1; pb[1] = 1'b1;
    pl[0] = 1'b0; pl[1] = 1'b0; lat_w[0] = 0; lat_w[1] = 0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        logic b, l;
        logic [23:0] e;
        b = c ? rb : lb;
        l = c ? rl : ll;
        if (b && !pb[c]) col[c] = {col[c][22:0], dsd};
        if (l) lat_w[c]++;
        if (l && !pl[c]) begin
          check(dsd == 1'b0, "R9", "data at strobe is pad zero", {31'd0, dsd}, 32'd0);
          if ((c ? exp_r.size() : exp_l.size()) == 0) begin
            check(1'b0, "R7", "unexpected latch pulse", 32'd1, 32'd0);
          end else begin
            e = c ? exp_r.pop_front() : exp_l.pop_front();
            check(col[c] == e, "R3", "emitted word", {8'd0, col[c]}, {8'd0, e});
          end
        end
        if (!l && pl[c]) begin
          check(lat_w[c] == 16, "R6", "strobe width", lat_w[c], 32'd16);
          lat_w[c] = 0;
        end
        pb[c] = b;
        pl[c] = l;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] w;
    sv[0] = 0; sv[1] = 0; sw[0] = '0; sw[1] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(lb == 1'b1, "R1", "left clock after reset", {31'd0, lb}, 32'd1);
    check(rb == 1'b1, "R1", "right clock after reset", {31'd0, rb}, 32'd1);
    check(ll == 1'b0 && rl == 1'b0, "R1", "strobes after reset", {30'd0, ll, rl}, 32'd0);
    check(dsd == 1'b0, "R1", "data after reset", {31'd0, dsd}, 32'd0);

    send_slot(1, 4, 16'h0000);      // arms framing, incomplete
    send_slot(0, 32, 16'hFFFF);     // R2 captures
    send_slot(1, 32, 16'h8001);
    send_slot(0, 32, 16'h0000);     // R3 emits FFFF
    send_slot(1, 32, 16'hA5A5);     // emits 8001
    send_slot(0, 12, 16'h1234);     // R7 discard, R8 abort
    send_slot(1, 32, 16'h5A5A);     // emits A5A5
    send_slot(0, 32, 16'h7E81);     // R7 quiet slot
    send_slot(1, 20, 16'h0F0F);     // R8 abort, still captured
    send_slot(0, 32, 16'hC3C3);     // emits 7E81
    send_slot(1, 32, 16'h1111);     // emits 0F0F
    w = 16'hACE1;
    for (int i = 0; i < 8; i++) begin
      w = {w[14:0], w[15] ^ w[13] ^ w[12] ^ w[10]};
      send_slot(0, 32, w);
      w = {w[14:0], w[15] ^ w[13] ^ w[12] ^ w[10]};
      send_slot(1, 32, w);
    end
    send_slot(0, 17, 16'h4BD2);     // R7 boundary: kept
    send_slot(1, 16, 16'h2222);     // R7 boundary: discarded
    send_slot(0, 26, 16'h3C3C);     // R6 boundary: latch, emits 4BD2
    send_slot(1, 32, 16'h9999);     // quiet
    send_slot(0, 32, 16'h6666);     // emits 3C3C
    send_slot(1, 32, 16'h0001);
    repeat (40) @(negedge clk);
    check(exp_l.size() == 0, "R6", "left strobes missing", exp_l.size(), 32'd0);
    check(exp_r.size() == 0, "R6", "right strobes missing", exp_r.size(), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule